// File: doc/BRIEF.md
# Thread Yield and Halt Controller

This block owns the run state of a single hardware thread context. It holds the thread's active flag, a restart address and the three-deep program counter sequence (current, next, next-next). Three commands act on that state: halt parks a running thread and remembers where it should pick up again; resume reloads the counter sequence from the remembered address and sets the thread running; yield evaluates a signed operand against a mask and either retires the thread voluntarily, raises a thread exception with a cause code, or does nothing beyond reporting the masked operand.

The thread's own binding (group and context number), the identity of the thread issuing the command, and the configuration flags that gate a yield (dynamically allocatable, halted, scheduler intercept, dirty) arrive as inputs from the surrounding control registers. Every result is registered, so each command takes effect on the first rising clock edge that samples it. Choosing which other thread runs next is the job of a separate scheduler.

Top module: `thread_runstate_ctrl`

## Requirements
- R1: After reset, active is 1, pc is RESET_PC (default 0x100), pc_next is RESET_PC+4, pc_next2 is RESET_PC+8, and restart_pc, yield_res, thread_fault and fault_cause are all 0.
- R2: A yield whose operand is 0 clears active when the thread is eligible: own_grp equals cur_grp, own_ctx equals cur_ctx, dyn_alloc is 1, halt_flag is 0 and active is 1. When any of these fails, active is unchanged. This yield never faults.
- R3: A yield with a positive operand and a mask of 0 pulses thread_fault and sets fault_cause to 2. With a nonzero mask a positive operand raises no fault and changes nothing else.
- R4: A yield with a negative operand other than -2 pulses thread_fault and sets fault_cause to 4 when sched_icpt and ctx_dirty are both 1; otherwise it raises no fault. An operand of exactly -2 never faults.
- R5: Every accepted yield loads yield_res with the bitwise AND of operand and mask; yield_res holds that value until the next accepted yield.
- R6: A halt while active clears active and loads restart_pc with next_pc_in; pc, pc_next and pc_next2 are unchanged.
- R7: A resume while inactive sets pc to restart_pc, pc_next to restart_pc+4, pc_next2 to restart_pc+8, and sets active.
- R8: A halt while inactive, or a resume while active, is ignored: active, restart_pc and the program counters keep their values.
- R9: When several commands arrive together exactly one is accepted, in the order halt, resume, yield; the others have no effect on any output, even if the accepted one is itself ignored.
- R10: thread_fault is high only in the cycle after a faulting yield is accepted; fault_cause keeps the most recent cause code until the next fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| yield_req | input | 1 | Yield command |
| halt_req | input | 1 | Halt command |
| resume_req | input | 1 | Resume command |
| yield_opnd | input | XLEN | Signed yield operand |
| yield_mask | input | XLEN | Yield qualifier mask |
| own_grp | input | GRP_W | Group the thread is bound to |
| own_ctx | input | CTX_W | Context number the thread is bound to |
| cur_grp | input | GRP_W | Group of the issuing thread |
| cur_ctx | input | CTX_W | Context number of the issuing thread |
| dyn_alloc | input | 1 | Thread is dynamically allocatable |
| halt_flag | input | 1 | Thread is held halted by software |
| sched_icpt | input | 1 | Scheduler intercept enable |
| ctx_dirty | input | 1 | Thread context dirty flag |
| next_pc_in | input | XLEN | Thread's next program counter, captured on halt |
| active | output | 1 | Thread is active |
| pc | output | XLEN | Current program counter |
| pc_next | output | XLEN | Next program counter |
| pc_next2 | output | XLEN | Program counter after next |
| restart_pc | output | XLEN | Restart address |
| yield_res | output | XLEN | Masked yield operand |
| thread_fault | output | 1 | One-cycle thread exception pulse |
| fault_cause | output | 3 | Most recent exception cause code |

## Verification
Every output of this block is a flop fed from the inputs of the same cycle, so the effect of a command, including the fault pulse and the new cause, is due on the first rising edge after it is presented and not later. The bench drives a command one nanosecond after an edge, steps its reference model once, waits for the next edge and compares all outputs one nanosecond after it, which also catches a fault pulse that lingers a second cycle. Ignored commands and losing commands of a collision are judged by the same comparison, since the model predicts held values for them.

// File: rtl/thrd_rs_pkg.sv
package thrd_rs_pkg;

  localparam int unsigned CAUSE_W = 3;

  // Exception cause codes decoded by the exception handler
  localparam logic [CAUSE_W-1:0] CAUSE_CLEAR     = 3'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_NOMASK    = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_INTERCEPT = 3'd4;

  typedef enum logic [1:0] {
    SEL_IDLE,
    SEL_HALT,
    SEL_RESUME,
    SEL_YIELD
  } cmd_sel_e;

  typedef struct packed {
    logic               fault;
    logic [CAUSE_W-1:0] code;
    logic               deact;
  } yield_verdict_t;

endpackage

// File: rtl/thrd_yield_eval.sv
module thrd_yield_eval
  import thrd_rs_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned GRP_W = 4,
  parameter int unsigned CTX_W = 8
) (
  input  logic signed [XLEN-1:0]  opnd,
  input  logic        [XLEN-1:0]  mask,
  input  logic        [GRP_W-1:0] own_grp,
  input  logic        [CTX_W-1:0] own_ctx,
  input  logic        [GRP_W-1:0] cur_grp,
  input  logic        [CTX_W-1:0] cur_ctx,
  input  logic                    dyn_alloc,
  input  logic                    halt_flag,
  input  logic                    active,
  input  logic                    sched_icpt,
  input  logic                    ctx_dirty,
  output yield_verdict_t          verdict
);

  // operand value that requests no action at all
  localparam logic [XLEN-1:0] SKIP_VAL = {{(XLEN-2){1'b1}}, 2'b10};

  logic eligible;
  logic is_zero;
  logic is_neg;
  logic is_skip;

  always_comb begin
    eligible = (own_grp == cur_grp) && (own_ctx == cur_ctx) &&
               dyn_alloc && !halt_flag && active;
    is_zero  = (opnd == '0);
    is_neg   = opnd[XLEN-1];
    is_skip  = (opnd == SKIP_VAL);

    verdict = '{fault: 1'b0, code: CAUSE_CLEAR, deact: 1'b0};
    if (is_zero) begin
      verdict.deact = eligible;
    end else if (!is_neg) begin
      if (mask == '0) begin
        verdict.fault = 1'b1;
        verdict.code  = CAUSE_NOMASK;
      end
    end else if (!is_skip) begin
      if (sched_icpt && ctx_dirty) begin
        verdict.fault = 1'b1;
        verdict.code  = CAUSE_INTERCEPT;
      end
    end
  end

  // R3 R4: a fault always carries one of the two yield cause codes
  always_comb begin
    if (verdict.fault) begin
      verdict_code_chk: assert (verdict.code == CAUSE_NOMASK || verdict.code == CAUSE_INTERCEPT);
    end
  end

endmodule

// File: rtl/thrd_pc_seq.sv
module thrd_pc_seq #(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     INSN_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC   = XLEN'(256)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [XLEN-1:0] cap_val,
  input  logic            load_en,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] pc_next2,
  output logic [XLEN-1:0] restart_pc
);

  localparam logic [XLEN-1:0] STEP1 = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * INSN_BYTES);

  logic [XLEN-1:0] restart_q, restart_d;
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] pcn_q, pcn_d;
  logic [XLEN-1:0] pcn2_q, pcn2_d;

  always_comb begin
    restart_d = cap_val;
    pc_d      = restart_q;
    pcn_d     = restart_q + STEP1;
    pcn2_d    = restart_q + STEP2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= '0;
      pc_q      <= RESET_PC;
      pcn_q     <= RESET_PC + STEP1;
      pcn2_q    <= RESET_PC + STEP2;
    end else begin
      if (cap_en) begin
        restart_q <= restart_d;
      end
      if (load_en) begin
        pc_q   <= pc_d;
        pcn_q  <= pcn_d;
        pcn2_q <= pcn2_d;
      end
    end
  end

  assign pc         = pc_q;
  assign pc_next    = pcn_q;
  assign pc_next2   = pcn2_q;
  assign restart_pc = restart_q;

  // R7: the sequence stays evenly spaced by one instruction
  pc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcn_q == pc_q + STEP1) && (pcn2_q == pcn_q + STEP1));

endmodule

// File: rtl/thread_runstate_ctrl.sv
module thread_runstate_ctrl
  import thrd_rs_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     GRP_W      = 4,
  parameter int unsigned     CTX_W      = 8,
  parameter int unsigned     INSN_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC   = XLEN'(256),
  parameter bit              RST_ACTIVE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    yield_req,
  input  logic                    halt_req,
  input  logic                    resume_req,
  input  logic signed [XLEN-1:0]  yield_opnd,
  input  logic        [XLEN-1:0]  yield_mask,
  input  logic        [GRP_W-1:0] own_grp,
  input  logic        [CTX_W-1:0] own_ctx,
  input  logic        [GRP_W-1:0] cur_grp,
  input  logic        [CTX_W-1:0] cur_ctx,
  input  logic                    dyn_alloc,
  input  logic                    halt_flag,
  input  logic                    sched_icpt,
  input  logic                    ctx_dirty,
  input  logic        [XLEN-1:0]  next_pc_in,
  output logic                    active,
  output logic        [XLEN-1:0]  pc,
  output logic        [XLEN-1:0]  pc_next,
  output logic        [XLEN-1:0]  pc_next2,
  output logic        [XLEN-1:0]  restart_pc,
  output logic        [XLEN-1:0]  yield_res,
  output logic                    thread_fault,
  output logic        [CAUSE_W-1:0] fault_cause
);

  localparam logic [XLEN-1:0] STEP1 = XLEN'(INSN_BYTES);

  cmd_sel_e        sel;
  yield_verdict_t  verdict;
  logic            active_q, active_d;
  logic            fault_q, fault_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [XLEN-1:0] res_q, res_d;
  logic            res_en;
  logic            cap_en;
  logic            load_en;

  thrd_yield_eval #(
    .XLEN  (XLEN),
    .GRP_W (GRP_W),
    .CTX_W (CTX_W)
  ) u_eval (
    .opnd       (yield_opnd),
    .mask       (yield_mask),
    .own_grp    (own_grp),
    .own_ctx    (own_ctx),
    .cur_grp    (cur_grp),
    .cur_ctx    (cur_ctx),
    .dyn_alloc  (dyn_alloc),
    .halt_flag  (halt_flag),
    .active     (active_q),
    .sched_icpt (sched_icpt),
    .ctx_dirty  (ctx_dirty),
    .verdict    (verdict)
  );

  // one command per cycle: halt, then resume, then yield
  always_comb begin
    if (halt_req)        sel = SEL_HALT;
    else if (resume_req) sel = SEL_RESUME;
    else if (yield_req)  sel = SEL_YIELD;
    else                 sel = SEL_IDLE;
  end

  always_comb begin
    active_d = active_q;
    cap_en   = 1'b0;
    load_en  = 1'b0;
    unique case (sel)
      SEL_HALT: begin
        if (active_q) begin
          active_d = 1'b0;
          cap_en   = 1'b1;
        end
      end
      SEL_RESUME: begin
        if (!active_q) begin
          active_d = 1'b1;
          load_en  = 1'b1;
        end
      end
      SEL_YIELD: begin
        if (verdict.deact) active_d = 1'b0;
      end
      default: ;
    endcase

    res_en  = (sel == SEL_YIELD);
    res_d   = yield_opnd & yield_mask;
    fault_d = (sel == SEL_YIELD) && verdict.fault;
    cause_d = fault_d ? verdict.code : cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= RST_ACTIVE;
      fault_q  <= 1'b0;
      cause_q  <= CAUSE_CLEAR;
      res_q    <= '0;
    end else begin
      active_q <= active_d;
      fault_q  <= fault_d;
      cause_q  <= cause_d;
      if (res_en) begin
        res_q <= res_d;
      end
    end
  end

  thrd_pc_seq #(
    .XLEN       (XLEN),
    .INSN_BYTES (INSN_BYTES),
    .RESET_PC   (RESET_PC)
  ) u_pcs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .cap_val    (next_pc_in),
    .load_en    (load_en),
    .pc         (pc),
    .pc_next    (pc_next),
    .pc_next2   (pc_next2),
    .restart_pc (restart_pc)
  );

  assign active       = active_q;
  assign thread_fault = fault_q;
  assign fault_cause  = cause_q;
  assign yield_res    = res_q;

  // R6
  halt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && active) |=> (!active && restart_pc == $past(next_pc_in)));

  // R8
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !active) |=> (!active && $stable(restart_pc) && $stable(pc)));

  // R7
  resume_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req && !halt_req && !active) |=>
      (active && pc == $past(restart_pc) && pc_next == pc + STEP1));

  // R9
  halt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && yield_req) |=> (!thread_fault && $stable(yield_res)));

  // R10
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thread_fault |-> (fault_cause == CAUSE_NOMASK || fault_cause == CAUSE_INTERCEPT));

endmodule

// File: tb/thread_runstate_ctrl_test.sv
`timescale 1ns/1ps
module thread_runstate_ctrl_test;

  localparam int          XLEN  = 32;
  localparam logic [31:0] RSTPC = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic               yield_req = 0, halt_req = 0, resume_req = 0;
  logic signed [31:0] yield_opnd = 0;
  logic        [31:0] yield_mask = 0;
  logic        [3:0]  own_grp = 0, cur_grp = 0;
  logic        [7:0]  own_ctx = 0, cur_ctx = 0;
  logic               dyn_alloc = 0, halt_flag = 0, sched_icpt = 0, ctx_dirty = 0;
  logic        [31:0] next_pc_in = 0;

  logic        active, thread_fault;
  logic [31:0] pc, pc_next, pc_next2, restart_pc, yield_res;
  logic [2:0]  fault_cause;

  thread_runstate_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .yield_req(yield_req), .halt_req(halt_req), .resume_req(resume_req),
    .yield_opnd(yield_opnd), .yield_mask(yield_mask),
    .own_grp(own_grp), .own_ctx(own_ctx), .cur_grp(cur_grp), .cur_ctx(cur_ctx),
    .dyn_alloc(dyn_alloc), .halt_flag(halt_flag), .sched_icpt(sched_icpt),
    .ctx_dirty(ctx_dirty), .next_pc_in(next_pc_in),
    .active(active), .pc(pc), .pc_next(pc_next), .pc_next2(pc_next2),
    .restart_pc(restart_pc), .yield_res(yield_res),
    .thread_fault(thread_fault), .fault_cause(fault_cause)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic        m_active;
  logic [31:0] m_pc, m_restart, m_res;
  logic        m_fault;
  logic [2:0]  m_cause;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic eligible_f();
    return (own_grp == cur_grp) && (own_ctx == cur_ctx) && dyn_alloc &&
           !halt_flag && m_active;
  endfunction

  // fault code predicted for a yield under the current inputs (0 = none)
  function automatic logic [2:0] yield_code_f();
    if (yield_opnd == 0) return 3'd0;
    if (yield_opnd > 0)  return (yield_mask == 0) ? 3'd2 : 3'd0;
    if (yield_opnd == -2) return 3'd0;
    return (sched_icpt && ctx_dirty) ? 3'd4 : 3'd0;
  endfunction

  task automatic compare(input string tg, input string ftg);
    chk(tg,    "active",      {31'd0, active},       {31'd0, m_active});
    chk(tg,    "pc",          pc,                    m_pc);
    chk(tg,    "pc_next",     pc_next,               m_pc + 32'd4);
    chk(tg,    "pc_next2",    pc_next2,              m_pc + 32'd8);
    chk(tg,    "restart_pc",  restart_pc,            m_restart);
    chk("R5",  "yield_res",   yield_res,             m_res);
    chk(ftg,   "fault",       {31'd0, thread_fault}, {31'd0, m_fault});
    chk("R10", "fault_cause", {29'd0, fault_cause},  {29'd0, m_cause});
  endtask

  // apply the currently driven inputs for one clock and compare
  task automatic step();
    string tg, ftg;
    int    ncmd;
    logic [2:0] code;
    ncmd = int'(yield_req) + int'(halt_req) + int'(resume_req);
    tg = "R10"; ftg = "R10";
    m_fault = 1'b0;
    if (halt_req) begin
      tg = (ncmd > 1) ? "R9" : (m_active ? "R6" : "R8");
      if (m_active) begin m_active = 1'b0; m_restart = next_pc_in; end
    end else if (resume_req) begin
      tg = (ncmd > 1) ? "R9" : (!m_active ? "R7" : "R8");
      if (!m_active) begin m_active = 1'b1; m_pc = m_restart; end
    end else if (yield_req) begin
      code = yield_code_f();
      if (yield_opnd == 0) tg = "R2";
      else if (yield_opnd > 0) begin tg = "R3"; ftg = "R3"; end
      else begin tg = "R4"; ftg = "R4"; end
      if (yield_opnd == 0 && eligible_f()) m_active = 1'b0;
      if (code != 0) begin m_fault = 1'b1; m_cause = code; end
      m_res = yield_opnd & yield_mask;
    end
    @(posedge clk);
    #1;
    compare(tg, ftg);
  endtask

  task automatic quiet();
    yield_req = 0; halt_req = 0; resume_req = 0;
  endtask

  task automatic good_bind();
    own_grp = 4'd3; cur_grp = 4'd3; own_ctx = 8'd17; cur_ctx = 8'd17;
    dyn_alloc = 1; halt_flag = 0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    m_active = 1'b1; m_pc = RSTPC; m_restart = 0; m_res = 0; m_fault = 0; m_cause = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1", "R1");

    // directed corner cases
    good_bind();
    quiet(); halt_req = 1; next_pc_in = 32'h4000; step();            // R6
    quiet(); halt_req = 1; next_pc_in = 32'h5550; step();            // R8 halt while inactive
    quiet(); resume_req = 1; step();                                 // R7
    quiet(); resume_req = 1; step();                                 // R8 resume while active
    quiet(); yield_req = 1; yield_opnd = 0; halt_flag = 1; step();   // R2 not eligible
    quiet(); yield_req = 1; yield_opnd = 0; halt_flag = 0; step();   // R2 eligible
    quiet(); resume_req = 1; step();
    quiet(); yield_req = 1; yield_opnd = 32'sd9; yield_mask = 0; step();     // R3 fault
    quiet(); step();                                                  // R10 pulse ends
    quiet(); yield_req = 1; yield_opnd = 32'sd9; yield_mask = 32'hF; step(); // R3 no fault
    sched_icpt = 1; ctx_dirty = 1;
    quiet(); yield_req = 1; yield_opnd = -32'sd5; yield_mask = 32'hFF; step(); // R4 fault
    quiet(); yield_req = 1; yield_opnd = -32'sd2; step();                     // R4 skip value
    quiet(); yield_req = 1; halt_req = 1; yield_opnd = 32'sd7; yield_mask = 0;
    next_pc_in = 32'h7000; step();                                    // R9 halt wins
    quiet(); resume_req = 1; yield_req = 1; yield_opnd = 32'sd3; yield_mask = 0; step(); // R9
    quiet(); step();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int k;
      yield_req  = ($urandom % 100) < 50;
      halt_req   = ($urandom % 100) < 15;
      resume_req = ($urandom % 100) < 18;
      k = $urandom % 5;
      case (k)
        0: yield_opnd = 0;
        1: yield_opnd = $signed({1'b0, 31'($urandom % 200 + 1)});
        2: yield_opnd = -32'sd2;
        3: yield_opnd = $signed({1'b1, 31'($urandom)});
        default: yield_opnd = $signed($urandom);
      endcase
      yield_mask = (($urandom % 4) == 0) ? 32'd0 : $urandom;
      own_grp = 4'($urandom); own_ctx = 8'($urandom);
      cur_grp = (($urandom % 5) != 0) ? own_grp : 4'($urandom);
      cur_ctx = (($urandom % 5) != 0) ? own_ctx : 8'($urandom);
      dyn_alloc  = ($urandom % 5) != 0;
      halt_flag  = ($urandom % 5) == 0;
      sched_icpt = $urandom % 2;
      ctx_dirty  = $urandom % 2;
      next_pc_in = {$urandom} & 32'hFFFF_FFFC;
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule